// File: doc/BRIEF.md
# Field Packet Framing Inserter

This block sits on a line-per-packet AXI4-Stream video path and turns a bare stream of video lines into one that carries in-band control packets. Each line is one packet, and the first beat of the first line of a field carries a start-of-field marker on `tuser[0]`. When the block sees that marker, it first closes the previous field with an end-of-field packet, then opens the new field with an image-information packet, and only then lets the marked line through. An in-band control packet is flagged by `tuser[1]` on its first beat. It uses only the low 16 bits of the data bus, and the bits above 16 are driven to zero.

The end-of-field packet reports two things: whether the field had the wrong number of lines, and a running field number. The running number counts up once per closed field, and a clear input can reset it to zero at any time. The end of a field is known only when the next start marker arrives, so a field's closing packet is sent at that point.

The same block also works in the reverse direction. When strip mode is selected, every packet whose first beat has `tuser[1]` set is removed completely, and all other packets pass through unchanged. Field geometry comes from static configuration inputs.

Top module: `field_pkt_framer`

## Requirements
- R1: After reset, with no input offered, `m_tvalid` is 0. The field number carried by the first end-of-field packet after reset is 0.
- R2: With `mode_strip`=1, a packet whose first beat has `tuser[1]`=1 is removed, including all of its beats. Every other packet comes out with the same data, tuser and tlast.
- R3: With `mode_strip`=0, the image-information packet is sent before the first line of every field. It is 3 beats long, and only its first beat has `tuser`=2'b10. Beat 0 holds type 0 in bits [4:0] and `cfg_ilace` in bits [7:6]. Beat 1 holds `cfg_width` in bits [15:0]. Beat 2 holds `cfg_height` in bits [15:0] and has tlast set.
- R4: The end-of-field packet for a field is sent only once the next start-of-field beat is offered, and it comes right before that field's image-information packet. It is 2 beats long, and only its first beat has `tuser`=2'b10. Beat 0 holds type 1 in bits [4:0]. Beat 1 has tlast set.
- R5: Bit 5 of the end-of-field beat 0 is 1 when the number of lines received in the field differs from `cfg_height`, and 0 when they are equal.
- R6: Bits [15:0] of end-of-field beat 1 carry the field number. The field number increases by one each time an end-of-field packet completes.
- R7: When `fld_clr` is high in a cycle, the field number becomes 0 in that cycle. This holds even when the same cycle completes an end-of-field packet.
- R8: In insert mode, video line beats pass through unchanged and keep their `tuser[0]` marker. An inserted beat keeps `m_tvalid` high and its data stable while `m_tready` is low.
- R9: The first field after reset is preceded by an image-information packet only, with no end-of-field packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_strip | input | 1 | 1: remove control packets; 0: insert field packets |
| cfg_width | input | 16 | Field width reported in image information |
| cfg_height | input | 16 | Expected lines per field |
| cfg_ilace | input | 2 | Interlace code reported in image information |
| fld_clr | input | 1 | Clears the field number |
| s_tdata | input | DATA_W | Input data |
| s_tuser | input | 2 | Input user bits: [0] start of field, [1] control packet |
| s_tlast | input | 1 | Input end of packet |
| s_tvalid | input | 1 | Input valid |
| s_tready | output | 1 | Input ready |
| m_tdata | output | DATA_W | Output data |
| m_tuser | output | 2 | Output user bits |
| m_tlast | output | 1 | Output end of packet |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |

## Verification
Two events can fall in the same clock edge: a field-number clear and the increment that completes an end-of-field packet. The bench provokes this by watching the output at the falling edge. When the second beat of an end-of-field packet is about to be accepted, the bench raises `fld_clr` for exactly that edge. The check is then made on the next field's closing packet, which must report 0 rather than the incremented number. A separate clear in the middle of a field checks the plain case, while a rotating backpressure pattern is applied to `m_tready`.

// File: rtl/field_pkt_framer.sv
module field_pkt_framer #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_strip,
  input  logic [15:0]       cfg_width,
  input  logic [15:0]       cfg_height,
  input  logic [1:0]        cfg_ilace,
  input  logic              fld_clr,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [1:0]        s_tuser,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [1:0]        m_tuser,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready
);
  typedef enum logic [2:0] {S_PASS, S_EOF0, S_EOF1, S_INF0, S_INF1, S_INF2} st_t;

  st_t              state;
  logic             first, in_drop, hdr_sent, field_open;
  logic [15:0]      line_cnt;
  logic [CNT_W-1:0] fld_cnt;
  logic [15:0]      word;
  logic [DATA_W-1:0] ins;
  logic             pass, stall, drop, in_acc, broken;

  assign pass   = (state == S_PASS);
  assign stall  = !mode_strip && s_tvalid && first && s_tuser[0] && !hdr_sent;
  assign drop   = mode_strip && (first ? s_tuser[1] : in_drop);
  assign broken = (line_cnt != cfg_height);

  always_comb begin
    case (state)
      S_EOF0:  word = {10'd0, broken, 5'd1};
      S_EOF1:  word = 16'(fld_cnt);
      S_INF0:  word = {8'd0, cfg_ilace, 6'd0};
      S_INF1:  word = cfg_width;
      default: word = cfg_height;
    endcase
    ins = '0;
    ins[15:0] = word;
  end

  assign m_tvalid = pass ? (s_tvalid && !drop && !stall) : 1'b1;
  assign s_tready = pass && !stall && (m_tready || drop);
  assign m_tdata  = pass ? s_tdata : ins;
  assign m_tuser  = pass ? s_tuser : ((state == S_EOF0 || state == S_INF0) ? 2'b10 : 2'b00);
  assign m_tlast  = pass ? s_tlast : (state == S_EOF1 || state == S_INF2);
  assign in_acc   = s_tvalid && s_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_PASS;
      first      <= 1'b1;
      in_drop    <= 1'b0;
      hdr_sent   <= 1'b0;
      field_open <= 1'b0;
      line_cnt   <= '0;
    end else begin
      if (in_acc) begin
        first   <= s_tlast;
        in_drop <= drop && !s_tlast;
        if (first && s_tuser[0] && !mode_strip) hdr_sent <= 1'b0;
        if (!mode_strip && s_tlast && field_open && line_cnt != 16'hFFFF)
          line_cnt <= line_cnt + 16'd1;
      end
      case (state)
        S_PASS: if (stall) state <= field_open ? S_EOF0 : S_INF0;
        S_EOF0: if (m_tready) state <= S_EOF1;
        S_EOF1: if (m_tready) begin
          state      <= S_INF0;
          field_open <= 1'b0;
        end
        S_INF0: if (m_tready) state <= S_INF1;
        S_INF1: if (m_tready) state <= S_INF2;
        default: if (m_tready) begin
          state      <= S_PASS;
          hdr_sent   <= 1'b1;
          field_open <= 1'b1;
          line_cnt   <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fld_clr) fld_cnt <= '0;
    else if (state == S_EOF1 && m_tready) fld_cnt <= fld_cnt + 1'b1;
  end

  assert_strip_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_strip && pass && s_tvalid && first && s_tuser[1]) |-> !m_tvalid);

  assert_eof_on_sof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EOF0) |-> (s_tvalid && first && s_tuser[0]));

  assert_sof_after_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_strip && m_tvalid && pass && first && m_tuser[0]) |-> hdr_sent);

  assert_clr_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fld_clr |=> (fld_cnt == '0));

  assert_ins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
endmodule

// File: tb/sim_field_pkt_framer.sv
module sim_field_pkt_framer;
  localparam int DW = 24;
  logic clk = 0, rst_n = 0;
  logic mode_strip = 0;
  logic [15:0] cfg_width = 16'd640, cfg_height = 16'd3;
  logic [1:0] cfg_ilace = 2'd0;
  logic clr_a = 0, clr_b = 0, fld_clr;
  logic [DW-1:0] s_tdata = '0;
  logic [1:0] s_tuser = '0;
  logic s_tlast = 0, s_tvalid = 0, s_tready;
  logic [DW-1:0] m_tdata;
  logic [1:0] m_tuser;
  logic m_tlast, m_tvalid, m_tready = 1;
  assign fld_clr = clr_a | clr_b;

  field_pkt_framer #(.DATA_W(DW)) u0 (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [DW-1:0] exp_d [0:511];
  logic [1:0]    exp_u [0:511];
  logic          exp_l [0:511];
  int            exp_r [0:511];
  int wr = 0, rd = 0;
  int cyc = 0;
  bit bp_on = 0, arm = 0, prev_eof0 = 0;
  int fnum = 0;

  task automatic push(input logic [DW-1:0] d, input logic [1:0] u, input logic l, input int r);
    exp_d[wr] = d; exp_u[wr] = u; exp_l[wr] = l; exp_r[wr] = r; wr++;
  endtask

  always @(posedge clk) begin
    cyc++;
    #1 m_tready = bp_on ? ((cyc % 3) != 1) : 1'b1;
  end

  always @(negedge clk) begin
    clr_b = 0;
    if (rst_n && m_tvalid && m_tready) begin
      checks++;
      if (rd >= wr) begin
        errors++;
        $display("FAIL R8 unexpected beat data=%h user=%b expected none", m_tdata, m_tuser);
      end else begin
        if (m_tdata !== exp_d[rd] || m_tuser !== exp_u[rd] || m_tlast !== exp_l[rd]) begin
          errors++;
          $display("FAIL R%0d beat %0d: got d=%h u=%b l=%b expected d=%h u=%b l=%b",
                   exp_r[rd], rd, m_tdata, m_tuser, m_tlast, exp_d[rd], exp_u[rd], exp_l[rd]);
        end
        rd++;
      end
      // R7 collision: clear rides the edge that completes the closing packet
      if (arm && prev_eof0 && m_tlast) begin clr_b = 1; arm = 0; end
      prev_eof0 = (m_tuser == 2'b10) && (m_tdata[4:0] == 5'd1);
    end
  end

  task automatic send_beat(input logic [DW-1:0] d, input logic [1:0] u, input logic l);
    s_tdata = d; s_tuser = u; s_tlast = l; s_tvalid = 1;
    forever begin
      @(negedge clk);
      if (s_tready) break;
    end
    @(posedge clk); #1;
    s_tvalid = 0;
  endtask

  task automatic send_line(input int f, input int ln, input bit sof, input bit expect_out, input int r);
    for (int b = 0; b < 4; b++) begin
      logic [DW-1:0] d = DW'((f << 16) | (ln << 8) | (b * 17 + 3));
      logic [1:0] u = {1'b0, sof && b == 0};
      if (expect_out) push(d, u, b == 3, r);
      send_beat(d, u, b == 3);
    end
  endtask

  // one field: optional closing packet for previous field, header, lines
  task automatic field(input int f, input int nlines, input bit has_prev,
                       input bit prev_broken, input int prev_cnt, input bit mid_clr);
    if (has_prev) begin
      push(DW'({prev_broken, 5'd1}), 2'b10, 1'b0, 5);   // R4/R5 beat 0
      push(DW'(prev_cnt), 2'b00, 1'b1, 6);              // R6 beat 1
    end
    push(DW'({cfg_ilace, 6'd0}), 2'b10, 1'b0, 3);       // R3 header
    push(DW'(cfg_width), 2'b00, 1'b0, 3);
    push(DW'(cfg_height), 2'b00, 1'b1, 3);
    for (int ln = 0; ln < nlines; ln++) begin
      send_line(f, ln, ln == 0, 1, 8);
      if (mid_clr && ln == 0) begin
        @(negedge clk); clr_a = 1; @(negedge clk); clr_a = 0;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (m_tvalid !== 1'b0) begin errors++; $display("FAIL R1 m_tvalid=%b expected 0", m_tvalid); end
    // insert mode; R9 first field has header only; R1 first count 0
    bp_on = 1;
    cfg_width = 16'd640; cfg_ilace = 2'd0;
    field(1, 3, 0, 0, 0, 0);
    cfg_width = 16'd720; cfg_ilace = 2'd2;
    field(2, 2, 1, 0, 0, 0);            // A closes: 3 lines, count 0
    cfg_width = 16'd1920; cfg_ilace = 2'd1;
    field(3, 4, 1, 1, 1, 1);            // B closes: 2 lines broken, count 1; clear inside C
    cfg_width = 16'd33; cfg_ilace = 2'd3;
    field(4, 3, 1, 1, 0, 0);            // C closes: 4 lines broken, count 0 after clear
    arm = 1;                            // R7 collision on D closing
    cfg_width = 16'd100; cfg_ilace = 2'd0;
    field(5, 3, 1, 0, 1, 0);            // D closes: good, count 1
    field(6, 1, 1, 0, 0, 0);            // E closes: count 0 since clear won
    repeat (20) @(negedge clk);
    checks++;
    if (rd != wr) begin errors++; $display("FAIL R4 beats seen %0d expected %0d", rd, wr); end
    checks++;
    if (arm) begin errors++; $display("FAIL R7 collision not provoked got 1 expected 0"); end
    // strip mode (R2): leftover open field is irrelevant here
    mode_strip = 1;
    send_line(9, 0, 1, 1, 2);
    send_beat(24'h000011, 2'b10, 0); send_beat(24'h000022, 2'b00, 1);
    send_line(9, 1, 0, 1, 2);
    send_beat(24'h000013, 2'b10, 1);
    send_line(9, 2, 0, 1, 2);
    for (int k = 0; k < 4; k++) send_beat(DW'(k), k == 0 ? 2'b10 : 2'b00, k == 3);
    send_line(9, 3, 1, 1, 2);
    repeat (20) @(negedge clk);
    checks++;
    if (rd != wr) begin errors++; $display("FAIL R2 beats seen %0d expected %0d", rd, wr); end
    checks++;
    if (m_tvalid !== 1'b0) begin errors++; $display("FAIL R2 idle m_tvalid=%b expected 0", m_tvalid); end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog expired got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule